// File: doc/BRIEF.md
# Serial Non-BCD Nibble Detector

This block watches a serial bit stream that arrives one bit per enabled clock. The stream is cut into consecutive 4-bit nibbles, and each nibble is sent with its least significant bit first. The block raises a flag in the cycle that carries the most significant bit of a nibble whose value is not a legal decimal digit, that is, a value from 10 through 15. It serves as an on-the-fly guard for packed-decimal serial data. The stream never has to be assembled into a parallel word.

The flag is a Mealy output: it is formed from the stored state and the live serial bit, so it has no register on the way to the port. The state holds little. A 2-bit position counter tracks where the current bit falls in its nibble. A single flag records whether bit 1 or bit 2 of that nibble was a one. Bit 0 plays no part in the decision, so states that differ only in bit 0 are merged. Nibble alignment is fixed by a synchronous reset. A bit-enable input lets the stream pause without disturbing the state.

Top module: `nibble_guard`

## Requirements
- R1: While `rst` is high, `illegal_o` is 0. After a clock edge with `rst` high, the next enabled bit is taken as bit 0 of a new nibble, even if reset came partway through a nibble.
- R2: Each enabled cycle (`bit_valid`=1) consumes one bit. Positions run 0,1,2,3 in that order (bit 0 = least significant) and then wrap to 0. The position does not change in a cycle with `bit_valid`=0.
- R3: In the enabled cycle that carries bit 3 of a nibble, `illegal_o` is 1 when the nibble value lies in 10..15, which is when bit3=1 and (bit2=1 or bit1=1).
- R4: `illegal_o` is 0 in every cycle that carries bit 0, 1 or 2. It is also 0 in the bit-3 cycle of a nibble with value 0..9.
- R5: With `bit_valid`=0, `illegal_o` is 0 whatever `ser_bit` does, and `ser_bit` has no effect on the result for the nibble in progress.
- R6: `illegal_o` depends combinationally on `ser_bit` during the bit-3 cycle. It responds in the same cycle, before the clock edge that consumes the bit.
- R7: Bit 0 has no effect on the decision. Values 8 and 9 are never flagged, and values 10 and 11 both are.
- R8: Nibbles may follow one another with no idle cycles between them. Each nibble gets its own decision, and the bits of one nibble do not carry into the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; realigns nibbles |
| bit_valid | input | 1 | High when `ser_bit` carries a stream bit this cycle |
| ser_bit | input | 1 | Serial data bit, least significant first within each nibble |
| illegal_o | output | 1 | High in the bit-3 cycle of a nibble valued 10..15 |

## Verification
Every cycle, the assertions check the following properties:
- The flag appears only on an enabled bit-3 cycle that carries a one.
- The position holds while the enable is low, and wraps after bit 3.
- The middle-bit flag is clear at the start of every nibble.
- Reset returns the state to its start point.

The directed scenarios are needed for the value-level behaviour: the flag tracks the full 16-value decode, bit 0 is ignored, reset realigns a stream partway through a nibble, and the output moves with `ser_bit` inside one cycle.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned POS_W = $clog2(NIB_W);

  typedef logic [POS_W-1:0] pos_t;

  localparam pos_t POS_FIRST = '0;
  localparam pos_t POS_LAST  = pos_t'(NIB_W - 1);

  // Bit positions 1 and 2 decide, together with bit 3, whether the value exceeds 9.
  function automatic logic is_middle_pos(input pos_t p);
    return (p == pos_t'(1)) || (p == pos_t'(2));
  endfunction

  // Value 10..15 <=> msb set and any middle bit set; bit 0 is irrelevant.
  function automatic logic over_nine(input logic msb, input logic any_mid);
    return msb & any_mid;
  endfunction
endpackage

// File: rtl/nbd_pos_ctr.sv
module nbd_pos_ctr
  import nbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output pos_t pos,
  output logic at_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= POS_FIRST;
    end else if (step) begin
      pos <= (pos == POS_LAST) ? POS_FIRST : pos + pos_t'(1);
    end
  end

  assign at_last = (pos == POS_LAST);
endmodule

// File: rtl/nbd_mid_track.sv
module nbd_mid_track
  import nbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic ser_bit,
  input  pos_t pos,
  output logic mid_seen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_seen <= 1'b0;
    end else if (step) begin
      if (pos == POS_LAST) begin
        mid_seen <= 1'b0;
      end else if (is_middle_pos(pos) && ser_bit) begin
        mid_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nbd_decide.sv
module nbd_decide
  import nbd_pkg::*;
(
  input  logic rst,
  input  logic step,
  input  logic at_last,
  input  logic ser_bit,
  input  logic mid_seen,
  output logic illegal
);
  assign illegal = !rst && step && at_last && over_nine(ser_bit, mid_seen);
endmodule

// File: rtl/nibble_guard.sv
module nibble_guard
  import nbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic ser_bit,
  output logic illegal_o
);
  logic nibble_step;
  pos_t cur_pos;
  logic last_bit;
  logic mid_seen;

  assign nibble_step = bit_valid;

  nbd_pos_ctr u_pos (
    .clk     (clk),
    .rst     (rst),
    .step    (nibble_step),
    .pos     (cur_pos),
    .at_last (last_bit)
  );

  nbd_mid_track u_mid (
    .clk      (clk),
    .rst      (rst),
    .step     (nibble_step),
    .ser_bit  (ser_bit),
    .pos      (cur_pos),
    .mid_seen (mid_seen)
  );

  nbd_decide u_dec (
    .rst      (rst),
    .step     (nibble_step),
    .at_last  (last_bit),
    .ser_bit  (ser_bit),
    .mid_seen (mid_seen),
    .illegal  (illegal_o)
  );
endmodule

// File: rtl/nibble_guard_chk.sv
module nibble_guard_chk
  import nbd_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic ser_bit,
  input logic illegal_o,
  input pos_t cur_pos,
  input logic mid_seen
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cur_pos == POS_FIRST && !mid_seen));

  // R5
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> bit_valid);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(cur_pos) && $stable(mid_seen));

  // R2
  wrap_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && cur_pos == POS_LAST) |=> cur_pos == POS_FIRST);

  // R4
  flag_only_on_msb_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (cur_pos == POS_LAST && ser_bit));

  // R8
  fresh_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_pos == POS_FIRST) |-> !mid_seen);
endmodule

bind nibble_guard nibble_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .ser_bit   (ser_bit),
  .illegal_o (illegal_o),
  .cur_pos   (cur_pos),
  .mid_seen  (mid_seen)
);

// File: tb/test_nibble_guard.sv
module test_nibble_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic ser_bit = 1'b0;
  logic illegal_o;

  int tests = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  nibble_guard i_nibble_guard (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .ser_bit   (ser_bit),
    .illegal_o (illegal_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic ref_bad(input logic [3:0] v);
    return v > 4'd9;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Drive one cycle at the falling edge and sample before the next rising edge.
  task automatic drive(input logic en, input logic b, input logic exp, input string tag);
    @(negedge clk);
    bit_valid = en;
    ser_bit   = b;
    #2;
    check(illegal_o, exp, tag);
  endtask

  task automatic send_nibble(input logic [3:0] v, input bit gaps, input string tag);
    for (int i = 0; i < 4; i++) begin
      if (gaps) begin
        step_lfsr();
        for (int g = 0; g < int'(lfsr[1:0]); g++) begin
          step_lfsr();
          drive(1'b0, lfsr[0], 1'b0, {tag, " R5 idle gap"});
        end
      end
      drive(1'b1, v[i], (i == 3) && ref_bad(v), tag);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b1; ser_bit = 1'b1;
    #2;
    check(illegal_o, 1'b0, "R1 output low during reset");
    @(negedge clk);
    rst = 1'b0;
    // Partial nibble, then reset realigns.
    drive(1'b1, 1'b1, 1'b0, "R1 partial bit0");
    drive(1'b1, 1'b1, 1'b0, "R1 partial bit1");
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    send_nibble(4'd12, 1'b0, "R1 realigned value 12");
    send_nibble(4'd3,  1'b0, "R1 realigned value 3");
  endtask

  task automatic test_all_values();
    for (int k = 0; k < 16; k++) begin
      logic [3:0] v;
      v = 4'((k * 7 + 3) % 16);
      send_nibble(v, 1'b1, $sformatf("R3 R4 R2 value %0d", v));
    end
  endtask

  task automatic test_back_to_back();
    send_nibble(4'd15, 1'b0, "R8 value 15");
    send_nibble(4'd0,  1'b0, "R8 value 0 after 15");
    send_nibble(4'd6,  1'b0, "R8 value 6");
    send_nibble(4'd8,  1'b0, "R8 value 8 after 6");
  endtask

  task automatic test_bit0_ignored();
    send_nibble(4'd10, 1'b0, "R7 value 10");
    send_nibble(4'd11, 1'b0, "R7 value 11");
    send_nibble(4'd8,  1'b0, "R7 value 8");
    send_nibble(4'd9,  1'b0, "R7 value 9");
  endtask

  task automatic test_enable_gap();
    // Value 14 = bits 0,1,1,1; idle MSB-like cycles with ser_bit high before the real bit 3.
    drive(1'b1, 1'b0, 1'b0, "R5 value14 bit0");
    drive(1'b0, 1'b1, 1'b0, "R5 idle high");
    drive(1'b1, 1'b1, 1'b0, "R5 value14 bit1");
    drive(1'b1, 1'b1, 1'b0, "R5 value14 bit2");
    drive(1'b0, 1'b1, 1'b0, "R5 idle high at msb slot");
    drive(1'b0, 1'b1, 1'b0, "R5 idle high at msb slot again");
    drive(1'b1, 1'b1, 1'b1, "R5 value14 bit3 flagged");
    // Value 1 with idle high bits in the middle: must stay unflagged.
    drive(1'b1, 1'b1, 1'b0, "R5 value1 bit0");
    drive(1'b0, 1'b1, 1'b0, "R5 idle high middle");
    drive(1'b1, 1'b0, 1'b0, "R5 value1 bit1");
    drive(1'b0, 1'b1, 1'b0, "R5 idle high middle 2");
    drive(1'b1, 1'b0, 1'b0, "R5 value1 bit2");
    drive(1'b1, 1'b0, 1'b0, "R5 value1 bit3");
  endtask

  task automatic test_mealy();
    // Value 6 bits go first (0,1,1), then the bit-3 cycle toggles ser_bit within one cycle.
    drive(1'b1, 1'b0, 1'b0, "R6 bit0");
    drive(1'b1, 1'b1, 1'b0, "R6 bit1");
    drive(1'b1, 1'b1, 1'b0, "R6 bit2");
    @(negedge clk);
    bit_valid = 1'b1; ser_bit = 1'b0;
    #2;
    check(illegal_o, 1'b0, "R6 msb low same cycle");
    ser_bit = 1'b1;
    #2;
    check(illegal_o, 1'b1, "R6 msb high same cycle");
    send_nibble(4'd2, 1'b0, "R6 next nibble value 2");
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R2 watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    test_all_values();
    test_back_to_back();
    test_bit0_ignored();
    test_enable_gap();
    test_mealy();
    drive(1'b0, 1'b0, 1'b0, "R4 idle end");
    finish_run();
  end
endmodule